// File: doc/BRIEF.md
# Serial 1-0-1 Pattern Detector

This block watches a single-bit serial stream, one bit taken on each rising clock edge, and raises a match flag whenever the three most recent bits, the current one included, read 1, 0, 1 in arrival order. The flag is Mealy-style. It is formed from the stored prefix progress and the bit presented now. As a result it rises in the same cycle that the completing 1 is on the input, and does not wait one cycle for a register.

Matches may overlap, so the final 1 of one match can serve as the first 1 of the next. The progress is held in a 2-bit state register with three legal codes. The fourth code cannot be reached in normal operation. If it appears, the output stays quiet and the machine leaves that code on the next edge. A synchronous active-high reset returns the machine to the no-prefix state.

Top module: `pattern_detect_mealy`

## Requirements
- R1: After a synchronous reset, the state is "no prefix" (code 00), so a 1 presented in the first cycle after reset does not raise `match_o`.
- R2: `match_o` is 1 exactly when the bit on `serial_in` is 1, the bit taken on the previous edge was 0, and the bit before that was 1. Both earlier bits must have been taken after reset. In every other case `match_o` is 0.
- R3: `match_o` is combinational from the state and `serial_in`, so it rises in the same cycle as the completing 1, with no added cycle of latency.
- R4: Detection overlaps. The stream 1,0,1,0,1 raises `match_o` on the third bit and again on the fifth.
- R5: Any run of 1s keeps the "1 seen" progress (code 01), so 1,1,1,0,1 matches on its last bit.
- R6: A 0 arriving while "10 seen" (code 10) is held drops the progress to "no prefix", so 1,0,0,1 does not match.
- R7: While the state register holds the unused code 11, `match_o` is 0 for either input value. On the next edge the state moves to "no prefix" (code 00) whatever the input is, so a following 1 does not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| serial_in | input | 1 | Serial data bit, taken each edge |
| match_o | output | 1 | High while the current bit completes 1,0,1 |

## Verification
The block's only sizes are the 2-bit state width and its enumerated codes from the package. The bench therefore builds it with those defaults, and every code, including the unreachable 11, is in reach. The bench brings the machine into code 11 by overriding the state register for one cycle. It then shows at the ports that the output stays low and that the next 1 finds no prefix. Directed streams and long random streams are compared on every cycle against a history of the last two bits.

// File: rtl/pd_pkg.sv
package pd_pkg;
  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    PFX_NONE    = 2'b00,
    PFX_ONE     = 2'b01,
    PFX_ONEZERO = 2'b10,
    PFX_BAD     = 2'b11
  } pfx_e;
endpackage

// File: rtl/pd_next_logic.sv
module pd_next_logic
  import pd_pkg::*;
(
  input  pfx_e cur,
  input  logic bit_in,
  output pfx_e nxt,
  output logic hit
);
  always_comb begin
    nxt = PFX_NONE;
    hit = 1'b0;
    unique case (cur)
      PFX_NONE:    nxt = bit_in ? PFX_ONE : PFX_NONE;
      PFX_ONE:     nxt = bit_in ? PFX_ONE : PFX_ONEZERO;
      PFX_ONEZERO: begin
        nxt = bit_in ? PFX_ONE : PFX_NONE;
        hit = bit_in;
      end
      default: begin
        nxt = PFX_NONE;
        hit = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/pd_state_reg.sv
module pd_state_reg
  import pd_pkg::*;
#(
  parameter pfx_e RESET_CODE = PFX_NONE
) (
  input  logic clk,
  input  logic rst,
  input  pfx_e nxt,
  output pfx_e cur
);
  pfx_e state_q;

  always_ff @(posedge clk) begin
    if (rst) state_q <= RESET_CODE;
    else     state_q <= nxt;
  end

  assign cur = state_q;

  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> state_q == RESET_CODE);
endmodule

// File: rtl/pattern_detect_mealy.sv
module pattern_detect_mealy
  import pd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic serial_in,
  output logic match_o
);
  pfx_e cur_state;
  pfx_e nxt_state;
  logic hit;

  pd_state_reg #(.RESET_CODE(PFX_NONE)) u_state (
    .clk (clk),
    .rst (rst),
    .nxt (nxt_state),
    .cur (cur_state)
  );

  pd_next_logic u_logic (
    .cur    (cur_state),
    .bit_in (serial_in),
    .nxt    (nxt_state),
    .hit    (hit)
  );

  assign match_o = hit;

  // R2
  match_history_chk: assert property (@(posedge clk) disable iff (rst)
    match_o |-> (serial_in && !$past(serial_in) && $past(serial_in, 2)));

  // R5
  hold_one_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_state == PFX_ONE && serial_in) |=> cur_state == PFX_ONE);

  // R6
  drop_prefix_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_state == PFX_ONEZERO && !serial_in) |=> cur_state == PFX_NONE);

  // R7
  bad_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cur_state == PFX_BAD |-> !match_o);

  // R7
  bad_exit_chk: assert property (@(posedge clk) disable iff (rst)
    cur_state == PFX_BAD |=> cur_state == PFX_NONE);
endmodule

// File: tb/test_pattern_detect_mealy.sv
module test_pattern_detect_mealy;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic serial_in = 1'b0;
  logic match_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [1:0] hist = 2'b00;
  int nvalid = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pattern_detect_mealy i_pattern_detect_mealy (
    .clk       (clk),
    .rst       (rst),
    .serial_in (serial_in),
    .match_o   (match_o)
  );

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic check(input string tag, input logic exp);
    checks++;
    if (match_o !== exp) begin
      errors++;
      $display("FAIL %s: match_o=%b expected %b at %0t", tag, match_o, exp, $time);
    end
  endtask

  // drive one bit, check output during that cycle, update reference
  task automatic step(input logic b, input string tag);
    logic exp;
    @(negedge clk);
    serial_in = b;
    #1;
    exp = (nvalid >= 2) && hist[1] && !hist[0] && b;
    check(tag, exp);
    hist = {hist[0], b};
    if (nvalid < 2) nvalid++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    serial_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    hist = 2'b00;
    nvalid = 0;
  endtask

  task automatic t_reset();
    do_reset();
    step(1'b1, "R1");
    step(1'b0, "R1");
    step(1'b1, "R1");
  endtask

  task automatic t_basic();
    do_reset();
    step(1'b1, "R3");
    step(1'b0, "R3");
    step(1'b1, "R3");
    step(1'b1, "R2");
    step(1'b1, "R2");
  endtask

  task automatic t_overlap();
    logic [4:0] s = 5'b10101;
    do_reset();
    for (int i = 4; i >= 0; i--) step(s[i], "R4");
    step(1'b0, "R4");
    step(1'b1, "R4");
  endtask

  task automatic t_ones();
    logic [4:0] s = 5'b11101;
    do_reset();
    for (int i = 4; i >= 0; i--) step(s[i], "R5");
  endtask

  task automatic t_zeros();
    logic [5:0] s = 6'b100101;
    do_reset();
    for (int i = 5; i >= 0; i--) step(s[i], "R6");
  endtask

  task automatic t_random();
    do_reset();
    for (int i = 0; i < 2000; i++) step(1'($urandom_range(0, 1)), "R2");
  endtask

  task automatic t_bad(input logic b);
    do_reset();
    step(1'b1, "R7");
    step(1'b0, "R7");
    @(negedge clk);
    force i_pattern_detect_mealy.u_state.state_q = pd_pkg::PFX_BAD;
    #1;
    release i_pattern_detect_mealy.u_state.state_q;
    serial_in = b;
    #1;
    check("R7", 1'b0);
    serial_in = 1'b1;
    #1;
    check("R7", 1'b0);
    serial_in = b;
    hist = 2'b00;
    nvalid = 0;
    step(1'b1, "R7");
    step(1'b0, "R7");
    step(1'b1, "R7");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
  end

  initial begin
    t_reset();
    t_basic();
    t_overlap();
    t_ones();
    t_zeros();
    t_bad(1'b0);
    t_bad(1'b1);
    t_random();
    report();
  end
endmodule